// File: doc/BRIEF.md
# Planar Blit Raster-Op Engine

This engine carries out a single block-transfer instruction on a frame buffer made of four byte-wide planes. Each plane sits in one byte lane of a 32-bit memory word. The caller presents the decoded instruction fields and pulses `start`. The engine then walks a rectangle of bytes at a time, one scanline after the next. For every byte it reads the source word and then the destination word. Each plane's source byte is rotated right, and each plane's source and destination may be inverted on their own. Every plane then applies its own logical operation, and the result is written back under a per-bit write mask.

The write mask merges three things: the plane enable, a head mask for the first byte processed on each scanline, and a tail mask for the last byte processed. A reverse flag walks the rows right-to-left and bottom-to-top, and the caller then supplies negative pitches. A sync flag holds the instruction back until vertical retrace is seen.

The state machine has six states:

- `ST_IDLE` waits for `start`. It moves to `ST_WAIT_VR` when the sync flag is set, and to `ST_FETCH_SRC` otherwise.
- `ST_WAIT_VR` moves to `ST_FETCH_SRC` once `vretrace` is high.
- `ST_FETCH_SRC` always moves to `ST_FETCH_DST`.
- `ST_FETCH_DST` always moves to `ST_STORE`.
- `ST_STORE` moves to `ST_FETCH_SRC` on the next byte or the next row. After the final byte it moves to `ST_FINISH`.
- `ST_FINISH` always moves to `ST_IDLE`.

Top module: `planar_blit_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R2: Plane p (byte lane p, bits 8p+7..8p) combines source S and destination D according to {cfg_op_hi[p], cfg_op_lo[p]}: 00 writes S, 01 writes S AND D, 10 writes S OR D, 11 writes S XOR D.
- R3: When cfg_src_inv[p] is set, plane p's source byte is inverted before the operation. When cfg_dst_inv[p] is set, plane p's destination byte is inverted before the operation. Bytes outside the write mask keep their stored value.
- R4: Each plane's source byte is rotated right by cfg_rotate bit positions before inversion and the operation.
- R5: A plane whose cfg_plane_en bit is clear is never written: its eight mem_wmask bits are zero.
- R6: The first byte processed in each row is written under cfg_head_mask, the last under cfg_tail_mask, and all others under all ones. When a row is one byte wide, the head and tail masks are ANDed together.
- R7: In forward mode a row holds cfg_span+1 bytes at rising addresses. Each new row starts at the previous row start plus the sign-extended 9-bit pitch, for source and destination separately. Read data is taken one cycle after `mem_rd`.
- R8: When cfg_reverse is set, the address falls by one per byte within a row, and the caller supplies negative pitches.
- R9: With cfg_sync set, no memory access happens until `vretrace` has been seen high after the start.
- R10: `busy` is high from the cycle after an accepted start through the single-cycle `done` pulse. Each byte takes three cycles, so an unsynchronised run of N bytes keeps `busy` high for 3N+1 cycles. Start and the instruction fields are ignored while busy.
- R11: A row count of zero runs exactly one row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| cfg_sync | input | 1 | Wait for vertical retrace before starting |
| cfg_reverse | input | 1 | Walk right-to-left, bottom-to-top |
| cfg_plane_en | input | 4 | Per-plane write enable |
| cfg_op_lo | input | 4 | Low bit of each plane's operation code |
| cfg_op_hi | input | 4 | High bit of each plane's operation code |
| cfg_src_inv | input | 4 | Per-plane source inversion |
| cfg_dst_inv | input | 4 | Per-plane destination inversion |
| cfg_head_mask | input | 8 | Bit mask for the first byte of each row |
| cfg_tail_mask | input | 8 | Bit mask for the last byte of each row |
| cfg_span | input | 16 | Row width in bytes minus one |
| cfg_rows | input | 10 | Number of rows |
| cfg_src_addr | input | 18 | First source byte address |
| cfg_dst_addr | input | 18 | First destination byte address |
| cfg_src_pitch | input | 9 | Signed source row step |
| cfg_dst_pitch | input | 9 | Signed destination row step |
| cfg_rotate | input | 3 | Right-rotate amount for source bytes |
| vretrace | input | 1 | Vertical retrace indication |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 32 | Write data, one byte lane per plane |
| mem_wmask | output | 32 | Per-bit write enable |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checks assume that the memory returns read data exactly one cycle after a read strobe. They also assume that the instruction fields are stable in the cycle `start` is accepted. The plane-enable check compares write masks against the enable value captured at that accepted start.

The stimulus keeps every source and destination rectangle inside a 4096-word window, so the bench memory never aliases. Negative pitches are supplied only together with the reverse flag, and `vretrace` is held low through every synchronised wait window. While an instruction runs, the bench deliberately pulses `start` again with scrambled fields. The assertions treat that pulse as ignored.

// File: rtl/blit_pkg.sv
package blit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_VR,
        ST_FETCH_SRC,
        ST_FETCH_DST,
        ST_STORE,
        ST_FINISH
    } blit_state_e;

    typedef enum logic [1:0] {
        LOP_COPY = 2'b00,
        LOP_AND  = 2'b01,
        LOP_OR   = 2'b10,
        LOP_XOR  = 2'b11
    } blit_lop_e;

endpackage

// File: rtl/blit_plane_alu.sv
module blit_plane_alu
    import blit_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ROT_W  = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] src_byte,
    input  logic [BYTE_W-1:0] dst_byte,
    input  logic [ROT_W-1:0]  rot,
    input  logic              inv_src,
    input  logic              inv_dst,
    input  logic [1:0]        op,
    output logic [BYTE_W-1:0] result
);
    localparam int DBL_W = 2 * BYTE_W;

    logic [DBL_W-1:0]  doubled;
    logic [BYTE_W-1:0] s_eff;
    logic [BYTE_W-1:0] d_eff;

    always_comb begin
        // Right-rotate: shift the byte concatenated with itself.
        doubled = {src_byte, src_byte} >> rot;
        s_eff   = inv_src ? ~doubled[BYTE_W-1:0] : doubled[BYTE_W-1:0];
        d_eff   = inv_dst ? ~dst_byte : dst_byte;

        unique case (blit_lop_e'(op))
            LOP_COPY: result = s_eff;
            LOP_AND:  result = s_eff & d_eff;
            LOP_OR:   result = s_eff | d_eff;
            LOP_XOR:  result = s_eff ^ d_eff;
            default:  result = s_eff;
        endcase
    end
endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
    parameter int ADDR_W  = 18,
    parameter int PITCH_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               reverse,
    input  logic               step_col,
    input  logic               step_row,
    output logic [ADDR_W-1:0]  addr
);
    localparam int EXT_W = ADDR_W - PITCH_W;

    logic [ADDR_W-1:0] row_base_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] next_row;

    assign next_row = row_base_q + {{EXT_W{pitch[PITCH_W-1]}}, pitch};
    assign addr     = cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_base_q <= '0;
            cur_q      <= '0;
        end else if (load) begin
            row_base_q <= load_addr;
            cur_q      <= load_addr;
        end else if (step_row) begin
            row_base_q <= next_row;
            cur_q      <= next_row;
        end else if (step_col) begin
            cur_q <= reverse ? cur_q - 1'b1 : cur_q + 1'b1;
        end
    end
endmodule

// File: rtl/planar_blit_engine.sv
module planar_blit_engine
    import blit_pkg::*;
#(
    parameter int PLANES  = 4,
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 18,
    parameter int PITCH_W = 9,
    parameter int SPAN_W  = 16,
    parameter int ROWS_W  = 10,
    parameter int ROT_W   = $clog2(BYTE_W),
    parameter int DATA_W  = PLANES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cfg_sync,
    input  logic               cfg_reverse,
    input  logic [PLANES-1:0]  cfg_plane_en,
    input  logic [PLANES-1:0]  cfg_op_lo,
    input  logic [PLANES-1:0]  cfg_op_hi,
    input  logic [PLANES-1:0]  cfg_src_inv,
    input  logic [PLANES-1:0]  cfg_dst_inv,
    input  logic [BYTE_W-1:0]  cfg_head_mask,
    input  logic [BYTE_W-1:0]  cfg_tail_mask,
    input  logic [SPAN_W-1:0]  cfg_span,
    input  logic [ROWS_W-1:0]  cfg_rows,
    input  logic [ADDR_W-1:0]  cfg_src_addr,
    input  logic [ADDR_W-1:0]  cfg_dst_addr,
    input  logic [PITCH_W-1:0] cfg_src_pitch,
    input  logic [PITCH_W-1:0] cfg_dst_pitch,
    input  logic [ROT_W-1:0]   cfg_rotate,
    input  logic               vretrace,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [DATA_W-1:0]  mem_wmask,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done
);
    blit_state_e state_q, state_d;

    logic               reverse_q;
    logic [PLANES-1:0]  plane_q, lop_lo_q, lop_hi_q, sinv_q, dinv_q;
    logic [BYTE_W-1:0]  head_q, tail_q;
    logic [SPAN_W-1:0]  span_q, col_q;
    logic [ROWS_W-1:0]  rows_q, row_q;
    logic [PITCH_W-1:0] spitch_q, dpitch_q;
    logic [ROT_W-1:0]   rot_q;
    logic [DATA_W-1:0]  src_word_q;

    logic              accept, last_col, last_row, step_col, step_row;
    logic [ROWS_W:0]   row_next;
    logic [BYTE_W-1:0] byte_mask;
    logic [DATA_W-1:0] rop_word;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    assign accept   = (state_q == ST_IDLE) && start;
    assign last_col = (col_q == span_q);
    assign row_next = {1'b0, row_q} + {{ROWS_W{1'b0}}, 1'b1};
    assign last_row = (row_next >= {1'b0, rows_q});
    assign step_col = (state_q == ST_STORE) && !last_col;
    assign step_row = (state_q == ST_STORE) && last_col && !last_row;

    blit_addr_gen #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_src_addr (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_addr(cfg_src_addr),
        .pitch(spitch_q), .reverse(reverse_q), .step_col(step_col),
        .step_row(step_row), .addr(src_addr)
    );

    blit_addr_gen #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_dst_addr (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_addr(cfg_dst_addr),
        .pitch(dpitch_q), .reverse(reverse_q), .step_col(step_col),
        .step_row(step_row), .addr(dst_addr)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        blit_plane_alu #(.BYTE_W(BYTE_W), .ROT_W(ROT_W)) u_alu (
            .src_byte (src_word_q[p*BYTE_W +: BYTE_W]),
            .dst_byte (mem_rdata[p*BYTE_W +: BYTE_W]),
            .rot      (rot_q),
            .inv_src  (sinv_q[p]),
            .inv_dst  (dinv_q[p]),
            .op       ({lop_hi_q[p], lop_lo_q[p]}),
            .result   (rop_word[p*BYTE_W +: BYTE_W])
        );
        assign mem_wmask[p*BYTE_W +: BYTE_W] = plane_q[p] ? byte_mask : '0;
    end

    always_comb begin
        byte_mask = '1;
        if (col_q == '0) byte_mask = byte_mask & head_q;
        if (last_col)    byte_mask = byte_mask & tail_q;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = cfg_sync ? ST_WAIT_VR : ST_FETCH_SRC;
            ST_WAIT_VR:   if (vretrace) state_d = ST_FETCH_SRC;
            ST_FETCH_SRC: state_d = ST_FETCH_DST;
            ST_FETCH_DST: state_d = ST_STORE;
            ST_STORE:     state_d = (last_col && last_row) ? ST_FINISH : ST_FETCH_SRC;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        mem_rd    = (state_q == ST_FETCH_SRC) || (state_q == ST_FETCH_DST);
        mem_wr    = (state_q == ST_STORE);
        mem_addr  = (state_q == ST_FETCH_SRC) ? src_addr : dst_addr;
        mem_wdata = rop_word;
    end

    // Instruction latch, counters and source capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reverse_q  <= 1'b0;
            plane_q    <= '0;
            lop_lo_q   <= '0;
            lop_hi_q   <= '0;
            sinv_q     <= '0;
            dinv_q     <= '0;
            head_q     <= '0;
            tail_q     <= '0;
            span_q     <= '0;
            rows_q     <= '0;
            spitch_q   <= '0;
            dpitch_q   <= '0;
            rot_q      <= '0;
            col_q      <= '0;
            row_q      <= '0;
            src_word_q <= '0;
        end else begin
            if (accept) begin
                reverse_q <= cfg_reverse;
                plane_q   <= cfg_plane_en;
                lop_lo_q  <= cfg_op_lo;
                lop_hi_q  <= cfg_op_hi;
                sinv_q    <= cfg_src_inv;
                dinv_q    <= cfg_dst_inv;
                head_q    <= cfg_head_mask;
                tail_q    <= cfg_tail_mask;
                span_q    <= cfg_span;
                rows_q    <= cfg_rows;
                spitch_q  <= cfg_src_pitch;
                dpitch_q  <= cfg_dst_pitch;
                rot_q     <= cfg_rotate;
                col_q     <= '0;
                row_q     <= '0;
            end
            if (state_q == ST_FETCH_DST) src_word_q <= mem_rdata;
            if (step_col) col_q <= col_q + 1'b1;
            if (step_row) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/blit_checker.sv
module blit_checker #(
    parameter int PLANES = 4,
    parameter int BYTE_W = 8,
    parameter int DATA_W = PLANES * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              cfg_sync,
    input logic              vretrace,
    input logic [PLANES-1:0] cfg_plane_en,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wmask
);
    logic              sync_pending_q;
    logic [PLANES-1:0] plane_en_q;
    logic [DATA_W-1:0] allowed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_pending_q <= 1'b0;
            plane_en_q     <= '0;
        end else if (start && !busy) begin
            sync_pending_q <= cfg_sync;
            plane_en_q     <= cfg_plane_en;
        end else if (vretrace) begin
            sync_pending_q <= 1'b0;
        end
    end

    always_comb begin
        for (int p = 0; p < PLANES; p++)
            allowed[p*BYTE_W +: BYTE_W] = {BYTE_W{plane_en_q[p]}};
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !done));

    assert_plane_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ((mem_wmask & ~allowed) == '0));

    assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_sync_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pending_q |-> (!mem_rd && !mem_wr));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
endmodule

bind planar_blit_engine blit_checker #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_blit_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cfg_sync(cfg_sync), .vretrace(vretrace), .cfg_plane_en(cfg_plane_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wmask(mem_wmask)
);

// File: tb/tb_planar_blit_engine.sv
module tb_planar_blit_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_sync = 1'b0, cfg_reverse = 1'b0;
    logic [3:0]  cfg_plane_en, cfg_op_lo, cfg_op_hi, cfg_src_inv, cfg_dst_inv;
    logic [7:0]  cfg_head_mask, cfg_tail_mask;
    logic [15:0] cfg_span;
    logic [9:0]  cfg_rows;
    logic [17:0] cfg_src_addr, cfg_dst_addr;
    logic [8:0]  cfg_src_pitch, cfg_dst_pitch;
    logic [2:0]  cfg_rotate;
    logic        vretrace = 1'b0;
    logic        mem_rd, mem_wr, busy, done;
    logic [17:0] mem_addr;
    logic [31:0] mem_wdata, mem_wmask, mem_rdata;

    logic [31:0] mem     [4096];
    logic [31:0] exp_mem [4096];

    int checks = 0;
    int errors = 0;
    int wr_in_wait;

    always #4 clk = ~clk;

    planar_blit_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_sync(cfg_sync),
        .cfg_reverse(cfg_reverse), .cfg_plane_en(cfg_plane_en),
        .cfg_op_lo(cfg_op_lo), .cfg_op_hi(cfg_op_hi),
        .cfg_src_inv(cfg_src_inv), .cfg_dst_inv(cfg_dst_inv),
        .cfg_head_mask(cfg_head_mask), .cfg_tail_mask(cfg_tail_mask),
        .cfg_span(cfg_span), .cfg_rows(cfg_rows),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_pitch(cfg_src_pitch), .cfg_dst_pitch(cfg_dst_pitch),
        .cfg_rotate(cfg_rotate), .vretrace(vretrace),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata),
        .busy(busy), .done(done)
    );

    // Bench memory: synchronous read, masked write
    always @(posedge clk) begin
        if (mem_wr)
            mem[mem_addr[11:0]] <= (mem[mem_addr[11:0]] & ~mem_wmask) | (mem_wdata & mem_wmask);
        if (mem_rd)
            mem_rdata <= mem[mem_addr[11:0]];
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] rop_ref(input logic [7:0] s, input logic [7:0] d,
                                           input int rot, input bit si, input bit di,
                                           input logic [1:0] op);
        logic [7:0] rs, a, b;
        rs = 8'((s >> rot) | (s << (8 - rot)));
        a = si ? ~rs : rs;
        b = di ? ~d : d;
        case (op)
            2'b00: return a;
            2'b01: return a & b;
            2'b10: return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic ref_run();
        int sb = int'(cfg_src_addr);
        int db = int'(cfg_dst_addr);
        int nrows = (cfg_rows == 0) ? 1 : int'(cfg_rows);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c <= int'(cfg_span); c++) begin
                int sa = cfg_reverse ? sb - c : sb + c;
                int da = cfg_reverse ? db - c : db + c;
                logic [31:0] sw = exp_mem[sa & 12'hFFF];
                logic [31:0] dw = exp_mem[da & 12'hFFF];
                logic [7:0] bm = 8'hFF;
                if (c == 0) bm &= cfg_head_mask;
                if (c == int'(cfg_span)) bm &= cfg_tail_mask;
                for (int p = 0; p < 4; p++) begin
                    logic [7:0] res = rop_ref(sw[p*8 +: 8], dw[p*8 +: 8], int'(cfg_rotate),
                                              cfg_src_inv[p], cfg_dst_inv[p],
                                              {cfg_op_hi[p], cfg_op_lo[p]});
                    logic [7:0] m = cfg_plane_en[p] ? bm : 8'h00;
                    dw[p*8 +: 8] = (dw[p*8 +: 8] & ~m) | (res & m);
                end
                exp_mem[da & 12'hFFF] = dw;
            end
            sb += int'($signed(cfg_src_pitch));
            db += int'($signed(cfg_dst_pitch));
        end
    endtask

    task automatic defaults();
        cfg_sync = 0; cfg_reverse = 0;
        cfg_plane_en = 4'hF; cfg_op_lo = 4'h0; cfg_op_hi = 4'h0;
        cfg_src_inv = 4'h0; cfg_dst_inv = 4'h0;
        cfg_head_mask = 8'hFF; cfg_tail_mask = 8'hFF;
        cfg_span = 16'd3; cfg_rows = 10'd2;
        cfg_src_addr = 18'd1024; cfg_dst_addr = 18'd2048;
        cfg_src_pitch = 9'd32; cfg_dst_pitch = 9'd32; cfg_rotate = 3'd0;
    endtask

    task automatic run(input string req, input int wait_cycles);
        int nbytes = (int'(cfg_span) + 1) * ((cfg_rows == 0) ? 1 : int'(cfg_rows));
        int busy_cnt = 0;
        int done_cnt = 0;
        int sample = 0;
        int bad = -1;
        for (int i = 0; i < 4096; i++) begin
            mem[i] = $urandom;
            exp_mem[i] = mem[i];
        end
        ref_run();
        wr_in_wait = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            sample++;
            if (cfg_sync && sample <= wait_cycles && mem_wr) wr_in_wait++;
            if (sample == 1) begin
                // R10: scrambled start while busy must be ignored
                start = 1'b1;
                cfg_plane_en = ~cfg_plane_en; cfg_op_lo = ~cfg_op_lo;
                cfg_rotate = cfg_rotate + 3'd1; cfg_dst_addr = 18'd100;
            end else begin
                start = 1'b0;
            end
            if (cfg_sync && sample == wait_cycles) vretrace = 1'b1;
            if (done) break;
            @(negedge clk);
        end
        vretrace = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4096; i++)
            if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        check(bad < 0, {req, " memory contents"}, (bad < 0) ? 0 : mem[bad],
              (bad < 0) ? 0 : exp_mem[bad]);
        check(busy_cnt == 3 * nbytes + 1 + wait_cycles, "R10 busy cycles",
              busy_cnt, 3 * nbytes + 1 + wait_cycles);
        check(done_cnt == 1, "R10 done pulse count", done_cnt, 1);
        check(!busy && !done, "R1 idle after done", {busy, done}, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        defaults();
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R1 reset state",
              {busy, done, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_wr, "R1 idle after reset release", {busy, mem_wr}, 0);

        // R2: one operation per plane (plane0 copy, 1 AND, 2 OR, 3 XOR)
        defaults(); cfg_op_lo = 4'b1010; cfg_op_hi = 4'b1100;
        run("R2 per-plane ops", 0);

        // R3: inversions
        defaults(); cfg_src_inv = 4'b0101; cfg_dst_inv = 4'b0011;
        cfg_op_lo = 4'hF; cfg_op_hi = 4'h0;
        run("R3 inversion", 0);

        // R4: rotation
        defaults(); cfg_rotate = 3'd3;
        run("R4 rotate 3", 0);
        defaults(); cfg_rotate = 3'd7; cfg_op_hi = 4'hF; cfg_op_lo = 4'hF;
        run("R4 rotate 7 xor", 0);

        // R5: plane enables
        defaults(); cfg_plane_en = 4'b0110;
        run("R5 plane enable", 0);

        // R6: head/tail masks, wide and single-byte rows
        defaults(); cfg_head_mask = 8'hF0; cfg_tail_mask = 8'h3C; cfg_span = 16'd5;
        run("R6 head tail masks", 0);
        defaults(); cfg_head_mask = 8'hF0; cfg_tail_mask = 8'h3C; cfg_span = 16'd0;
        cfg_rows = 10'd3;
        run("R6 single byte AND", 0);

        // R7: multi-row forward with distinct pitches
        defaults(); cfg_span = 16'd6; cfg_rows = 10'd5;
        cfg_src_pitch = 9'd20; cfg_dst_pitch = 9'd40;
        run("R7 forward rows", 0);

        // R8: reverse direction with negative pitches
        defaults(); cfg_reverse = 1; cfg_span = 16'd4; cfg_rows = 10'd4;
        cfg_src_addr = 18'd1500; cfg_dst_addr = 18'd2600;
        cfg_src_pitch = -9'sd24; cfg_dst_pitch = -9'sd36; cfg_head_mask = 8'h0F;
        run("R8 reverse", 0);

        // R9: sync wait
        defaults(); cfg_sync = 1;
        run("R9 sync wait", 15);
        check(wr_in_wait == 0, "R9 writes before retrace", wr_in_wait, 0);

        // R11: zero rows
        defaults(); cfg_rows = 10'd0; cfg_span = 16'd2;
        run("R11 zero rows", 0);

        // Random instructions
        for (int k = 0; k < 24; k++) begin
            defaults();
            cfg_plane_en  = 4'($urandom);
            cfg_op_lo     = 4'($urandom);
            cfg_op_hi     = 4'($urandom);
            cfg_src_inv   = 4'($urandom);
            cfg_dst_inv   = 4'($urandom);
            cfg_head_mask = 8'($urandom);
            cfg_tail_mask = 8'($urandom);
            cfg_rotate    = 3'($urandom);
            cfg_span      = 16'($urandom_range(0, 7));
            cfg_rows      = 10'($urandom_range(0, 5));
            cfg_reverse   = 1'($urandom);
            cfg_src_addr  = 18'(1300 + $urandom_range(0, 200));
            cfg_dst_addr  = 18'(2500 + $urandom_range(0, 200));
            cfg_src_pitch = 9'($urandom_range(8, 40));
            cfg_dst_pitch = 9'($urandom_range(8, 40));
            if (cfg_reverse) begin
                cfg_src_pitch = -cfg_src_pitch;
                cfg_dst_pitch = -cfg_dst_pitch;
            end
            run("R2 R3 R4 R5 R6 R7 R8 random", 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule